// File: doc/BRIEF.md
# Asynchronous ROM Read-Cycle Controller

This block sits on the host side of an asynchronous byte-wide nonvolatile memory and turns a one-cycle read request into a timed access of that memory. On an accepted request it registers the address, drives it out, and pulls the active-low chip enable low. It then pulls the active-low output enable low in a later step. After both access deadlines have passed it captures the byte and returns it with a one-cycle valid strobe.

Every wait is a whole number of system clock cycles. Each one is derived at elaboration time from a nanosecond timing parameter and the clock period, rounded up. Output enable is delayed after chip enable by the address access time minus the output-enable access time, which does not lengthen the access. After each read, both enables stay high for a release interval, so that the memory can stop driving the bus before the next access starts. With no request pending, chip enable stays high and the memory is held in standby.

Top module: `rom_read_ctrl`

## Requirements
- R1: Under reset and on the first cycle after it, `mem_ce_n` and `mem_oe_n` are 1, `rsp_valid` is 0 and `req_ready` is 1. A reset asserted during an access ends that access at once.
- R2: A request is accepted only while `req_ready` is 1. The address is registered on the accepting edge, and `mem_addr` holds that value until the access ends, whatever `req_addr` does in the meantime.
- R3: `mem_ce_n` falls on the accepting edge. `mem_oe_n` falls LAG cycles later, where LAG = ceil(T_ACC/CLK) - ceil(T_OE/CLK), clamped at 0. With the defaults (20 ns clock, 70 ns, 35 ns) LAG is 2.
- R4: The byte on `mem_rdata` is captured one clock after the later of the two deadlines: ceil(T_ACC/CLK) cycles after chip enable falls, or ceil(T_OE/CLK) cycles after output enable falls. It is returned on `rsp_data` with `rsp_valid` high. With the defaults this is 5 cycles after the accepting edge.
- R5: Output enable is never low while chip enable is high. Both enables rise together on the capture edge.
- R6: After the capture edge, `req_ready` stays 0 and both enables stay high for REL_WAIT cycles. REL_WAIT is the larger of ceil(T_REL/CLK) and the shortfall against the minimum read cycle. With the defaults this is 2 cycles, so chip enable is high for at least 25 ns between accesses.
- R7: `rsp_valid` is a single-cycle pulse, issued exactly once for each accepted request.
- R8: While no request is present, `mem_ce_n` and `mem_oe_n` stay 1 indefinitely (standby).
- R9: A request held high continuously is accepted again as soon as `req_ready` returns. With the defaults, successive chip-enable falls are 8 cycles apart, which is never less than the 70 ns minimum read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_ready | output | 1 | High when idle and able to accept a request |
| mem_addr | output | ADDR_W | Address bus to the memory |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_oe_n | output | 1 | Active-low output enable (bus-drive flag) |
| mem_rdata | input | DATA_W | Data bus from the memory |
| rsp_valid | output | 1 | One-cycle strobe marking returned data |
| rsp_data | output | DATA_W | Captured byte |

## Verification
Two functions can land on the same clock edge: the end of one access (capture, raising both enables, entering release) and the arrival of the next request. The bench provokes this by holding `req_valid` high through several reads and by changing `req_addr` while an access is still running. The outcome is judged at the ports. The held request must wait out the full release interval: successive chip-enable falls must be exactly 8 cycles and at least 25 ns apart. `mem_addr` must not follow the changed request address. The bench's memory model returns the correct byte only when both access deadlines have truly passed, so each returned byte must match that model.

// File: rtl/rom_read_ctrl.sv
module rom_read_ctrl #(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 20,
  parameter int T_ACC_NS  = 70,
  parameter int T_OE_NS   = 35,
  parameter int T_CYC_NS  = 70,
  parameter int T_REL_NS  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int ACC_CYC  = (T_ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int OE_CYC   = (T_OE_NS  + CLK_NS - 1) / CLK_NS;
  localparam int REL_CYC  = (T_REL_NS + CLK_NS - 1) / CLK_NS;
  localparam int CYC_CYC  = (T_CYC_NS + CLK_NS - 1) / CLK_NS;
  localparam int LAG      = (ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0;
  localparam int OE_DONE  = LAG + OE_CYC;
  localparam int DEAD     = (ACC_CYC > OE_DONE) ? ACC_CYC : OE_DONE;
  localparam int SHORT    = (CYC_CYC > DEAD + 1) ? CYC_CYC - DEAD - 1 : 0;
  localparam int REL_RAW  = (REL_CYC > SHORT) ? REL_CYC : SHORT;
  localparam int REL_WAIT = (REL_RAW < 1) ? 1 : REL_RAW;
  localparam int CMAX     = (DEAD > REL_WAIT) ? DEAD : REL_WAIT;
  localparam int CW       = $clog2(CMAX + 2);

  localparam logic [CW-1:0] LAG_C  = CW'(LAG);
  localparam logic [CW-1:0] DEAD_C = CW'(DEAD);
  localparam logic [CW-1:0] REL_C  = CW'(REL_WAIT - 1);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_REL} state_t;

  state_t        st;
  logic [CW-1:0] cnt;

  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          mem_ce_n <= 1'b0;
          mem_oe_n <= (LAG != 0);
          cnt      <= '0;
          st       <= S_ACC;
        end
        S_ACC: if (cnt == DEAD_C) begin
          rsp_data  <= mem_rdata;
          rsp_valid <= 1'b1;
          mem_ce_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          cnt       <= '0;
          st        <= S_REL;
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt + 1'b1 == LAG_C) mem_oe_n <= 1'b0;
        end
        S_REL: if (cnt == REL_C) begin
          cnt <= '0;
          st  <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_oe_under_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n);
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  assert_capture_after_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!mem_oe_n) && $past(!mem_ce_n)));
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_release_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |=> (mem_ce_n && !req_ready));
  assert_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n));
endmodule

// File: tb/tb_rom_read_ctrl.sv
`timescale 1ns/100ps
module tb_rom_read_ctrl;
  localparam int AW = 18;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n;
  logic [DW-1:0] mem_rdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rsp_count = 0;
  int ce_fall_cyc = 0;
  int ce_gap_cyc = 0;
  real t_ce_fall = 0.0, t_oe_fall = 0.0, t_addr = 0.0, t_ce_rise = -1000.0;
  real min_gap_ns = 1.0e9;

  rom_read_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (rst_n && rsp_valid) rsp_count <= rsp_count + 1;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[15:10], a[17:16]} ^ 8'h5A;
  endfunction

  always @(mem_addr) t_addr = $realtime;
  always @(negedge mem_oe_n) t_oe_fall = $realtime;
  always @(posedge mem_ce_n) t_ce_rise = $realtime;
  always @(negedge mem_ce_n) begin
    t_ce_fall = $realtime;
    if (t_ce_fall - t_ce_rise < min_gap_ns) min_gap_ns = t_ce_fall - t_ce_rise;
    ce_gap_cyc = cyc - ce_fall_cyc;
    ce_fall_cyc = cyc;
  end

  initial begin
    #0.5;
    forever begin
      if (!mem_ce_n && !mem_oe_n && ($realtime - t_ce_fall >= 70.0) &&
          ($realtime - t_addr >= 70.0) && ($realtime - t_oe_fall >= 35.0))
        mem_rdata = pat(mem_addr);
      else
        mem_rdata = ~pat(mem_addr);
      #1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n, "R1 enables high in reset", {mem_ce_n, mem_oe_n}, 3);
    chk(!rsp_valid && req_ready, "R1 idle flags in reset", {rsp_valid, req_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && req_ready, "R1 after reset", {mem_ce_n, mem_oe_n, req_ready}, 7);
  endtask

  task automatic read_one(input logic [AW-1:0] a);
    chk(req_ready, "R2 ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a;
    chk(!mem_ce_n, "R3 ce falls on accept", mem_ce_n, 0);
    chk(mem_oe_n, "R3 oe still high at accept", mem_oe_n, 1);
    chk(mem_addr == a, "R2 address registered", mem_addr, a);
    @(negedge clk);
    chk(mem_oe_n, "R3 oe high one cycle after", mem_oe_n, 1);
    @(negedge clk);
    chk(!mem_oe_n, "R3 oe low after lag", mem_oe_n, 0);
    @(negedge clk);
    @(negedge clk);
    chk(!rsp_valid, "R4 no early response", rsp_valid, 0);
    chk(mem_addr == a, "R2 address held", mem_addr, a);
    @(negedge clk);
    chk(rsp_valid, "R4 response strobe", rsp_valid, 1);
    chk(rsp_data == pat(a), "R4 response data", rsp_data, pat(a));
    chk(mem_ce_n && mem_oe_n, "R5 enables rise together", {mem_ce_n, mem_oe_n}, 3);
    chk(!req_ready, "R6 busy in release", req_ready, 0);
    @(negedge clk);
    chk(!rsp_valid, "R7 strobe single cycle", rsp_valid, 0);
    chk(!req_ready && mem_ce_n, "R6 release second cycle", {req_ready, mem_ce_n}, 1);
    @(negedge clk);
    chk(req_ready, "R6 idle after release", req_ready, 1);
  endtask

  task automatic standby_test();
    bit ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!mem_ce_n || !mem_oe_n || rsp_valid) ok = 1'b0;
    end
    chk(ok, "R8 standby while idle", ok, 1);
  endtask

  task automatic back_to_back();
    int start_cnt;
    bit gaps_ok = 1'b1;
    start_cnt = rsp_count;
    req_valid = 1'b1; req_addr = 18'h2A5C3;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      repeat (8) @(negedge clk);
      if (ce_gap_cyc != 8) gaps_ok = 1'b0;
    end
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(gaps_ok, "R9 accept spacing 8 cycles", ce_gap_cyc, 8);
    chk(rsp_count - start_cnt == 4, "R7 one strobe per request", rsp_count - start_cnt, 4);
    chk(rsp_data == pat(18'h2A5C3), "R4 data in back-to-back", rsp_data, pat(18'h2A5C3));
    chk(min_gap_ns >= 25.0, "R6 ce high at least 25 ns", int'(min_gap_ns), 25);
  endtask

  task automatic reset_mid_access();
    req_valid = 1'b1; req_addr = 18'h00077;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(mem_ce_n && mem_oe_n, "R1 reset aborts access", {mem_ce_n, mem_oe_n}, 3);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!rsp_valid && req_ready, "R1 no response after abort", {rsp_valid, req_ready}, 1);
  endtask

  initial begin
    fork
      begin
        do_reset();
        read_one(18'h00000);
        read_one(18'h3FFFF);
        read_one(18'h1B2C4);
        standby_test();
        back_to_back();
        reset_mid_access();
        read_one(18'h0F0F0);
      end
      begin
        #(200000 * 20);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule